// File: doc/BRIEF.md
# In-Order Retirement Buffer with Operand Lookup

This block holds the results of instructions that have been issued but not yet retired. It is a circular buffer of eight entries. Each entry carries an instruction kind, a destination register and a result value. An entry is claimed at the tail in program order when an instruction issues, and the slot number it receives is that instruction's rename tag. Execution units later return a result together with this tag, which marks the entry complete. The entry at the head is handed to the architectural register file as soon as it is complete, and at most one entry leaves per cycle.

Two lookup ports are read in the same cycle as the register file. Each port takes a register number and searches every live entry that will write that register. If several entries match, the youngest one answers. A hit overrides the register-file copy. When the matching result has already arrived, the port returns that value. When it has not, the port returns the tag of the producing entry, so the consumer can capture the value later.

A flush input discards every entry at once.

Top module: `result_rob`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `cmt_valid` is 0, both lookup ports miss, and `alloc_tag` is 0.
- R2: Each accepted allocation receives the tag shown on `alloc_tag`. Tags run 0,1,2,… and wrap modulo 8 back to 0.
- R3: With 8 entries outstanding, `alloc_ready` is 0. An allocation request in that state creates no entry. Once an entry retires, `alloc_ready` returns to 1 on the following cycle.
- R4: A result write (`wr_valid`, `wr_tag`, `wr_data`) to an outstanding entry that is not yet complete marks that entry complete and stores the value. The write takes effect at the next clock edge.
- R5: Retirement is strictly in program order. A complete entry never retires while an older entry is incomplete, and at most one entry retires per cycle.
- R6: `cmt_valid` is 1 while the oldest entry is complete, with `cmt_reg` and `cmt_data` taken from that entry. `cmt_wen` is 1 for kind 0 (ALU) and kind 1 (LOAD). It is 0 for kind 2 (STORE) and kind 3 (BRANCH).
- R7: A lookup hits only when an outstanding entry of kind 0 or 1 has the requested destination. STORE and BRANCH entries, and entries already retired, never hit.
- R8: When several outstanding entries target the looked-up register, the youngest one supplies the lookup result.
- R9: On a hit, `q*_tag` is the matching entry's number. `q*_ready` is 1 and `q*_data` carries the stored result if that entry is complete. Otherwise `q*_ready` and `q*_data` are 0.
- R10: A cycle with `flush` high empties the buffer. The next cycle shows no retirement, misses on lookups, `alloc_ready` at 1, and `alloc_tag` at 0.
- R11: The two lookup ports answer independently and in the same cycle for different registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard all entries |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH |
| alloc_reg | input | 5 | Destination register of the new entry |
| alloc_ready | output | 1 | Buffer has a free entry |
| alloc_tag | output | 3 | Tag given to the next allocation |
| wr_valid | input | 1 | Result write strobe |
| wr_tag | input | 3 | Entry receiving the result |
| wr_data | input | 32 | Result value |
| cmt_valid | output | 1 | Oldest entry retires this cycle |
| cmt_wen | output | 1 | Retiring entry writes the register file |
| cmt_reg | output | 5 | Register written on retirement |
| cmt_data | output | 32 | Value written on retirement |
| qa_reg | input | 5 | Lookup A register number |
| qa_hit | output | 1 | Lookup A found a pending writer |
| qa_ready | output | 1 | Lookup A value is available |
| qa_tag | output | 3 | Lookup A producing entry |
| qa_data | output | 32 | Lookup A value |
| qb_reg | input | 5 | Lookup B register number |
| qb_hit | output | 1 | Lookup B found a pending writer |
| qb_ready | output | 1 | Lookup B value is available |
| qb_tag | output | 3 | Lookup B producing entry |
| qb_data | output | 32 | Lookup B value |

## Verification
The lookup ports are tried against a mixed buffer. In it, one register has an older pending writer and a younger completed one, which tells youngest-first from oldest-first selection. A second register has a STORE and a BRANCH entry with the same destination as a pending ALU entry, which tells kind filtering apart from plain destination matching. Further registers have no writer at all.

Results are returned out of program order, so in-order retirement can be told from retire-when-complete. The buffer is then filled past wrap-around until it is full, which exposes off-by-one errors in the full test and in tag wrapping. A flush while the buffer is full confirms that every entry and both pointers clear.

// File: rtl/result_rob.sv
module result_rob #(
  parameter int ENTRIES = 8,
  parameter int REGS    = 32,
  parameter int XLEN    = 32,
  localparam int TW     = $clog2(ENTRIES),
  localparam int RW     = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            alloc_valid,
  input  logic [1:0]      alloc_kind,
  input  logic [RW-1:0]   alloc_reg,
  output logic            alloc_ready,
  output logic [TW-1:0]   alloc_tag,
  input  logic            wr_valid,
  input  logic [TW-1:0]   wr_tag,
  input  logic [XLEN-1:0] wr_data,
  output logic            cmt_valid,
  output logic            cmt_wen,
  output logic [RW-1:0]   cmt_reg,
  output logic [XLEN-1:0] cmt_data,
  input  logic [RW-1:0]   qa_reg,
  output logic            qa_hit,
  output logic            qa_ready,
  output logic [TW-1:0]   qa_tag,
  output logic [XLEN-1:0] qa_data,
  input  logic [RW-1:0]   qb_reg,
  output logic            qb_hit,
  output logic            qb_ready,
  output logic [TW-1:0]   qb_tag,
  output logic [XLEN-1:0] qb_data
);
  // ENTRIES must be a power of two: pointers wrap by natural overflow.
  logic [ENTRIES-1:0] busy, done;
  logic [1:0]         kind [ENTRIES];
  logic [RW-1:0]      dst  [ENTRIES];
  logic [XLEN-1:0]    val  [ENTRIES];
  logic [TW-1:0]      head, tail;
  logic [TW:0]        cnt;
  logic               do_alloc, do_cmt, do_wr;

  assign alloc_ready = cnt != (TW+1)'(ENTRIES);
  assign alloc_tag   = tail;
  assign do_alloc    = alloc_valid && alloc_ready && !flush;

  assign cmt_valid = busy[head] && done[head];
  assign cmt_wen   = cmt_valid && !kind[head][1];
  assign cmt_reg   = dst[head];
  assign cmt_data  = val[head];
  assign do_cmt    = cmt_valid && !flush;

  assign do_wr = wr_valid && busy[wr_tag] && !done[wr_tag] && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      done <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (flush) begin
      busy <= '0;
      done <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (do_cmt) begin
        busy[head] <= 1'b0;
        done[head] <= 1'b0;
        head       <= head + TW'(1);
      end
      if (do_wr) done[wr_tag] <= 1'b1;
      if (do_alloc) begin
        busy[tail] <= 1'b1;
        done[tail] <= 1'b0;
        tail       <= tail + TW'(1);
      end
      cnt <= cnt + (TW+1)'(do_alloc) - (TW+1)'(do_cmt);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) val[wr_tag] <= wr_data;
    if (do_alloc) begin
      kind[tail] <= alloc_kind;
      dst[tail]  <= alloc_reg;
    end
  end

  // Walk from oldest to youngest so the last match is the youngest writer.
  always_comb begin
    logic [TW-1:0] idx;
    qa_hit = 1'b0;
    qa_tag = '0;
    qb_hit = 1'b0;
    qb_tag = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      idx = head + TW'(i);
      if (busy[idx] && !kind[idx][1] && dst[idx] == qa_reg) begin
        qa_hit = 1'b1;
        qa_tag = idx;
      end
      if (busy[idx] && !kind[idx][1] && dst[idx] == qb_reg) begin
        qb_hit = 1'b1;
        qb_tag = idx;
      end
    end
  end

  assign qa_ready = qa_hit && done[qa_tag];
  assign qa_data  = qa_ready ? val[qa_tag] : '0;
  assign qb_ready = qb_hit && done[qb_tag];
  assign qb_data  = qb_ready ? val[qb_tag] : '0;

  // R2
  tag_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !flush) |=> alloc_tag == $past(alloc_tag) + TW'(1));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !flush) |=> $stable(alloc_tag));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (TW+1)'(ENTRIES));

  // R5
  one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (head == $past(head) || head == $past(head) + TW'(1)));

  // R9
  hit_live_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qa_hit |-> busy[qa_tag]);

  // R9
  hit_live_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qb_hit |-> busy[qb_tag]);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alloc_ready && !cmt_valid && alloc_tag == '0));
endmodule

// File: tb/result_rob_tb.sv
module result_rob_tb;
  logic        clk = 0, rst_n = 0, flush = 0;
  logic        alloc_valid = 0;
  logic [1:0]  alloc_kind = 0;
  logic [4:0]  alloc_reg = 0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        wr_valid = 0;
  logic [2:0]  wr_tag = 0;
  logic [31:0] wr_data = 0;
  logic        cmt_valid, cmt_wen;
  logic [4:0]  cmt_reg;
  logic [31:0] cmt_data;
  logic [4:0]  qa_reg = 0, qb_reg = 0;
  logic        qa_hit, qa_ready, qb_hit, qb_ready;
  logic [2:0]  qa_tag, qb_tag;
  logic [31:0] qa_data, qb_data;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  result_rob u_dut (.*);

  // row: reg[41:37] hit[36] ready[35] tag[34:32] data[31:0]
  localparam int NROW = 5;
  localparam logic [41:0] LK [NROW] = '{
    {5'd3,  1'b1, 1'b1, 3'd2, 32'h22},
    {5'd5,  1'b1, 1'b1, 3'd1, 32'h11},
    {5'd7,  1'b0, 1'b0, 3'd0, 32'h0},
    {5'd9,  1'b1, 1'b0, 3'd5, 32'h0},
    {5'd12, 1'b0, 1'b0, 3'd0, 32'h0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic alloc(input logic [1:0] k, input logic [4:0] r, input logic [2:0] exp_tag);
    alloc_valid = 1; alloc_kind = k; alloc_reg = r;
    #1;
    chk("R2", "alloc_tag", 32'(alloc_tag), 32'(exp_tag));
    tick();
    alloc_valid = 0;
  endtask

  task automatic wr(input logic [2:0] t, input logic [31:0] d);
    wr_valid = 1; wr_tag = t; wr_data = d;
    tick();
    wr_valid = 0;
  endtask

  task automatic commit_chk(input string req, input logic v, input logic we, input logic [4:0] r, input logic [31:0] d);
    chk(req, "cmt_valid", 32'(cmt_valid), 32'(v));
    if (v) begin
      chk(req, "cmt_wen", 32'(cmt_wen), 32'(we));
      chk(req, "cmt_reg", 32'(cmt_reg), 32'(r));
      chk(req, "cmt_data", cmt_data, d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    tick();
    // R1 reset state
    qa_reg = 3; qb_reg = 5; #1;
    chk("R1", "alloc_ready", 32'(alloc_ready), 1);
    chk("R1", "alloc_tag", 32'(alloc_tag), 0);
    chk("R1", "cmt_valid", 32'(cmt_valid), 0);
    chk("R1", "qa_hit", 32'(qa_hit), 0);
    chk("R1", "qb_hit", 32'(qb_hit), 0);

    alloc(2'd0, 5'd3, 3'd0);
    alloc(2'd1, 5'd5, 3'd1);
    alloc(2'd0, 5'd3, 3'd2);
    alloc(2'd2, 5'd9, 3'd3);
    alloc(2'd3, 5'd9, 3'd4);
    alloc(2'd0, 5'd9, 3'd5);

    wr(3'd2, 32'h22);
    wr(3'd1, 32'h11);
    // R5 younger entries complete, oldest not: no retirement
    commit_chk("R5", 0, 0, 0, 0);

    // R7 R8 R9 R11 lookup table
    for (int i = 0; i < NROW; i++) begin
      logic [41:0] ra, rb;
      ra = LK[i];
      rb = LK[(i + 2) % NROW];
      qa_reg = ra[41:37];
      qb_reg = rb[41:37];
      #1;
      chk("R8", "qa_hit", 32'(qa_hit), 32'(ra[36]));
      chk("R9", "qa_ready", 32'(qa_ready), 32'(ra[35]));
      if (ra[36]) chk("R8", "qa_tag", 32'(qa_tag), 32'(ra[34:32]));
      chk("R9", "qa_data", qa_data, ra[31:0]);
      chk("R11", "qb_hit", 32'(qb_hit), 32'(rb[36]));
      chk("R11", "qb_ready", 32'(qb_ready), 32'(rb[35]));
      if (rb[36]) chk("R11", "qb_tag", 32'(qb_tag), 32'(rb[34:32]));
      chk("R11", "qb_data", qb_data, rb[31:0]);
    end

    wr(3'd0, 32'hA0);
    commit_chk("R6", 1, 1, 5'd3, 32'hA0);
    tick();
    commit_chk("R6", 1, 1, 5'd5, 32'h11);
    tick();
    commit_chk("R6", 1, 1, 5'd3, 32'h22);
    tick();
    commit_chk("R5", 0, 0, 0, 0);
    wr(3'd4, 32'h44);
    // R5 branch done but store ahead of it is not
    commit_chk("R5", 0, 0, 0, 0);
    wr(3'd3, 32'h33);
    commit_chk("R6", 1, 0, 5'd9, 32'h33);
    tick();
    commit_chk("R6", 1, 0, 5'd9, 32'h44);
    tick();
    commit_chk("R4", 0, 0, 0, 0);
    qa_reg = 3; qb_reg = 9; #1;
    chk("R7", "qa_hit retired", 32'(qa_hit), 0);
    chk("R9", "qb_hit pending", 32'(qb_hit), 1);
    chk("R9", "qb_ready pending", 32'(qb_ready), 0);
    chk("R9", "qb_tag pending", 32'(qb_tag), 5);

    // R3 fill to capacity across the wrap
    for (int k = 0; k < 7; k++) alloc(2'd0, 5'(10 + k), 3'(6 + k));
    #1;
    chk("R3", "alloc_ready full", 32'(alloc_ready), 0);
    alloc_valid = 1; alloc_kind = 0; alloc_reg = 20;
    tick(); tick();
    alloc_valid = 0;
    qa_reg = 20; qb_reg = 16; #1;
    chk("R3", "blocked alloc absent", 32'(qa_hit), 0);
    chk("R3", "alloc_tag held", 32'(alloc_tag), 5);
    chk("R8", "qb_tag wrapped", 32'(qb_tag), 4);
    wr(3'd5, 32'h55);
    commit_chk("R4", 1, 1, 5'd9, 32'h55);
    chk("R3", "alloc_ready still full", 32'(alloc_ready), 0);
    tick();
    chk("R3", "alloc_ready freed", 32'(alloc_ready), 1);
    chk("R2", "alloc_tag wrap", 32'(alloc_tag), 5);

    // R10 flush
    alloc(2'd0, 5'd21, 3'd5);
    flush = 1;
    tick();
    flush = 0;
    qa_reg = 10; qb_reg = 21; #1;
    chk("R10", "alloc_ready", 32'(alloc_ready), 1);
    chk("R10", "alloc_tag", 32'(alloc_tag), 0);
    chk("R10", "cmt_valid", 32'(cmt_valid), 0);
    chk("R10", "qa_hit", 32'(qa_hit), 0);
    chk("R10", "qb_hit", 32'(qb_hit), 0);
    alloc(2'd0, 5'd4, 3'd0);
    wr(3'd0, 32'h44);
    qa_reg = 4; #1;
    chk("R4", "qa_ready", 32'(qa_ready), 1);
    chk("R4", "qa_data", qa_data, 32'h44);
    commit_chk("R10", 1, 1, 5'd4, 32'h44);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule